// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block holds one byte of sticky error flags for a hardware monitor. Each implemented flag captures a one-cycle or longer error event from its event input and keeps it until software clears it through a small register port. A per-bit static mask and a sleep-state policy can stop an event from being captured. Clearing is refused while an unmasked event is still active. A mode pin decides whether a read of the status byte also clears it. Writing ones to the status byte always clears it.

The block also produces a registered summary flag, set when any status bit outside a configurable exclusion set is high. An alert output follows that summary flag when the alert-enable control bit is set. The register port has a write strobe, a read strobe, a two-bit address and a byte of write data. Read data is registered and is valid in the cycle after the read strobe.

Top module: `err_status_bank`

## Requirements
- R1: A status bit goes to 1 at the clock edge where its event input is high and unmasked. It stays at 1 after the event drops, until a clear is accepted.
- R2: A write to address 0 clears each status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R3: If an event is active and unmasked in the same cycle as a clear of its bit, the bit stays at 1, so the set wins.
- R4: The effective mask is the static mask register (address 1) ORed with the sleep-derived mask. A masked event does not set its bit. A masked bit can be cleared while its event is still active.
- R5: Sleep states are taken from control bits [1:0], coded 0 awake, 1 S3, 2 S4/5, 3 spare.
  - In S3 and S4/5, bits 2 and 3 are always masked. Bits 0 and 1 are masked only when the matching bit of the optional sleep-mask register (address 2) is 1. Bits 4 and 5 are never masked.
  - Codes 0 and 3 add no sleep masking.
- R6: When rc_mode_i is 1, a read of address 0 returns the status byte as it stood before the read, and clears all bits that are not re-set at that edge. When rc_mode_i is 0, reads never change the status.
- R7: Status bits 0..5 take event_i[0..5]. Bits 7:6 always read 0. After reset, all registers and outputs are 0.
- R8: summary_o is 1 one cycle after any status bit outside the exclusion parameter is 1. The bench configuration excludes bit 5.
- R9: alert_o is 1 one cycle after the summary condition holds while the alert-enable bit (control bit 2) is 1. Otherwise alert_o is 0.
- R10: The register port is decoded as follows:
  - Address 0 is the status byte. Address 1 is the static mask. Address 2 is the optional sleep-mask. Address 3 is control, with bit 2 the alert enable and bits [1:0] the sleep state.
  - Mask registers read back ANDed with the implemented bits (0x3F).
  - Read data appears in the cycle after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| event_i | input | 8 | Error event lines, one per status bit |
| rc_mode_i | input | 1 | 1: reading the status byte also clears it |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| summary_o | output | 1 | Registered summary error flag |
| alert_o | output | 1 | Registered alert output |

## Verification
A sweep drives all 64 event patterns under every sleep code, both optional-mask settings, two static-mask patterns and both clear modes. It reads the status after each pattern and then clears it. This separates static masking from sleep masking, and always-masked bits from optionally masked ones.

Directed sequences cover the remaining cases:
- A clear issued while an event is held, with and without a mask, separates refused clears from accepted ones.
- Back-to-back reads in each mode show whether a read clears.
- An event on the excluded bit shows whether it is kept out of the summary and alert paths.

// File: rtl/err_bank_pkg.sv
package err_bank_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 2;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [1:0] {
        SLP_AWAKE = 2'd0,
        SLP_S3    = 2'd1,
        SLP_S45   = 2'd2,
        SLP_SPARE = 2'd3
    } sleep_e;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS  = 2'd0,
        A_MASK    = 2'd1,
        A_OPTMASK = 2'd2,
        A_CTRL    = 2'd3
    } addr_e;

    typedef struct packed {
        logic   alert_en;
        sleep_e sleep;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_e addr;
        reg_t  wdata;
    } bus_req_t;

    typedef struct packed {
        reg_t always_s3;
        reg_t opt_s3;
        reg_t always_s45;
        reg_t opt_s45;
    } sleep_policy_t;

    function automatic reg_t sleep_mask(sleep_e st, sleep_policy_t pol, reg_t opt_en);
        reg_t m;
        case (st)
            SLP_S3:  m = pol.always_s3  | (pol.opt_s3  & opt_en);
            SLP_S45: m = pol.always_s45 | (pol.opt_s45 & opt_en);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/err_bank_cfg.sv
module err_bank_cfg
    import err_bank_pkg::*;
#(
    parameter reg_t          IMPL_MASK = 8'h3F,
    parameter sleep_policy_t POLICY    = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req_i,
    output reg_t     eff_mask_o,
    output reg_t     mask_rd_o,
    output reg_t     opt_rd_o,
    output ctrl_t    ctrl_o
);

    reg_t  mask_q;
    reg_t  opt_q;
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            opt_q  <= '0;
            ctrl_q <= '0;
        end else if (req_i.wr) begin
            case (req_i.addr)
                A_MASK:    mask_q <= req_i.wdata;
                A_OPTMASK: opt_q  <= req_i.wdata;
                A_CTRL:    ctrl_q <= ctrl_t'(req_i.wdata[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        eff_mask_o = (mask_q | sleep_mask(ctrl_q.sleep, POLICY, opt_q)) & IMPL_MASK;
        mask_rd_o  = mask_q & IMPL_MASK;
        opt_rd_o   = opt_q & IMPL_MASK;
        ctrl_o     = ctrl_q;
    end

    // A static mask bit always appears in the effective mask.
    AST_STATIC_IN_EFF: assert property (@(posedge clk) disable iff (rst)
        ((eff_mask_o & mask_rd_o) == mask_rd_o)) else $error("static mask lost"); // R4

endmodule

// File: rtl/err_bank_sticky.sv
module err_bank_sticky
    import err_bank_pkg::*;
#(
    parameter reg_t IMPL_MASK = 8'h3F
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_t     event_i,
    input  reg_t     eff_mask_i,
    input  logic     rc_mode_i,
    input  bus_req_t req_i,
    output reg_t     status_o
);

    reg_t status_q;
    reg_t cond;
    reg_t clr;
    reg_t status_d;

    always_comb begin
        cond = event_i & ~eff_mask_i & IMPL_MASK;
        clr  = '0;
        if (req_i.addr == A_STATUS) begin
            if (req_i.wr)
                clr = clr | req_i.wdata;
            if (req_i.rd && rc_mode_i)
                clr = '1;
        end
        status_d = ((status_q & ~clr) | cond) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr)))
        else $error("bit dropped without clear"); // R1

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (cond != '0) |=> ((status_q & $past(cond)) == $past(cond)))
        else $error("active event not held"); // R3

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & $past(eff_mask_i)) == '0))
        else $error("masked bit set"); // R4

    AST_NORMAL_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && !req_i.wr && !rc_mode_i && req_i.addr == A_STATUS)
        |=> ((status_q & $past(status_q)) == $past(status_q)))
        else $error("read cleared in normal mode"); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~IMPL_MASK) == '0)) else $error("reserved bit set"); // R7

endmodule

// File: rtl/err_bank_flags.sv
module err_bank_flags
    import err_bank_pkg::*;
#(
    parameter reg_t NOSUM_MASK = 8'h00
) (
    input  logic clk,
    input  logic rst,
    input  reg_t status_i,
    input  logic alert_en_i,
    output logic summary_o,
    output logic alert_o
);

    logic any_err;
    logic summary_q;
    logic alert_q;

    assign any_err = |(status_i & ~NOSUM_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            summary_q <= 1'b0;
            alert_q   <= 1'b0;
        end else begin
            summary_q <= any_err;
            alert_q   <= any_err & alert_en_i;
        end
    end

    assign summary_o = summary_q;
    assign alert_o   = alert_q;

    AST_ALERT_NEEDS_SUM: assert property (@(posedge clk) disable iff (rst)
        alert_q |-> summary_q) else $error("alert without summary"); // R9

    AST_ALERT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_q) |-> $past(alert_en_i)) else $error("alert while disabled"); // R9

    AST_SUM_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        $rose(summary_q) |-> ($past(status_i) != '0)) else $error("summary from nothing"); // R8

endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
    import err_bank_pkg::*;
#(
    parameter reg_t IMPL_MASK   = 8'h3F,
    parameter reg_t NOSUM_MASK  = 8'h00,
    parameter reg_t ALWAYS_S3   = 8'h0C,
    parameter reg_t OPT_S3      = 8'h03,
    parameter reg_t ALWAYS_S45  = 8'h0C,
    parameter reg_t OPT_S45     = 8'h03
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  event_i,
    input  logic              rc_mode_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              summary_o,
    output logic              alert_o
);

    localparam sleep_policy_t POLICY = '{
        always_s3:  ALWAYS_S3,
        opt_s3:     OPT_S3,
        always_s45: ALWAYS_S45,
        opt_s45:    OPT_S45
    };

    bus_req_t req;
    reg_t     eff_mask;
    reg_t     mask_rd;
    reg_t     opt_rd;
    ctrl_t    ctrl;
    reg_t     status;
    reg_t     rd_mux;
    reg_t     rd_q;

    always_comb begin
        req.wr    = wr_en_i;
        req.rd    = rd_en_i;
        req.addr  = addr_e'(addr_i);
        req.wdata = wdata_i;
    end

    err_bank_cfg #(
        .IMPL_MASK (IMPL_MASK),
        .POLICY    (POLICY)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .eff_mask_o (eff_mask),
        .mask_rd_o  (mask_rd),
        .opt_rd_o   (opt_rd),
        .ctrl_o     (ctrl)
    );

    err_bank_sticky #(
        .IMPL_MASK (IMPL_MASK)
    ) u_sticky (
        .clk        (clk),
        .rst        (rst),
        .event_i    (event_i),
        .eff_mask_i (eff_mask),
        .rc_mode_i  (rc_mode_i),
        .req_i      (req),
        .status_o   (status)
    );

    err_bank_flags #(
        .NOSUM_MASK (NOSUM_MASK)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .status_i   (status),
        .alert_en_i (ctrl.alert_en),
        .summary_o  (summary_o),
        .alert_o    (alert_o)
    );

    always_comb begin
        case (req.addr)
            A_STATUS:  rd_mux = status;
            A_MASK:    rd_mux = mask_rd;
            A_OPTMASK: rd_mux = opt_rd;
            default:   rd_mux = reg_t'(ctrl);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rd_data_o = rd_q;

    AST_RD_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && req.addr != A_CTRL) |=> ((rd_data_o & ~IMPL_MASK) == '0))
        else $error("reserved bits read nonzero"); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o)) else $error("read data moved"); // R10

endmodule

// File: tb/test_err_status_bank.sv
module test_err_status_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] IMPL  = 8'h3F;
    localparam logic [7:0] NOSUM = 8'h20;
    localparam logic [7:0] ALW   = 8'h0C;
    localparam logic [7:0] OPT   = 8'h03;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] event_i = '0;
    logic       rc_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       summary;
    logic       alert;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] m_stat = '0, m_mask = '0, m_opt = '0, m_rd = '0;
    logic [1:0] m_sleep = '0;
    logic       m_en = 1'b0, m_sum = 1'b0, m_alert = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_status_bank #(.NOSUM_MASK(NOSUM)) i_err_status_bank (
        .clk       (clk),
        .rst       (rst),
        .event_i   (event_i),
        .rc_mode_i (rc_mode),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rd_data_o (rd_data),
        .summary_o (summary),
        .alert_o   (alert)
    );

    function automatic logic [7:0] slp_mask(logic [1:0] st, logic [7:0] opt);
        if (st == 2'd1 || st == 2'd2) return ALW | (OPT & opt);
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Drives one cycle (called at a negedge), updates the model at the edge,
    // and compares outputs at the following negedge.
    task automatic cyc(logic [7:0] ev, logic wr, logic rd, logic [1:0] a,
                       logic [7:0] wd, string tag);
        logic [7:0] em, cond, clr;
        logic       nsum, nal;
        event_i = ev; wr_en = wr; rd_en = rd; addr = a; wdata = wd;
        @(posedge clk);
        em   = (m_mask | slp_mask(m_sleep, m_opt)) & IMPL;
        cond = ev & ~em & IMPL;
        clr  = '0;
        if (a == 2'd0) begin
            if (wr) clr = clr | wd;
            if (rd && rc_mode) clr = 8'hFF;
        end
        nsum = |(m_stat & ~NOSUM);
        nal  = nsum & m_en;
        if (rd) begin
            case (a)
                2'd0: m_rd = m_stat;
                2'd1: m_rd = m_mask & IMPL;
                2'd2: m_rd = m_opt & IMPL;
                default: m_rd = {5'b0, m_en, m_sleep};
            endcase
        end
        if (wr) begin
            case (a)
                2'd1: m_mask = wd;
                2'd2: m_opt = wd;
                2'd3: begin m_sleep = wd[1:0]; m_en = wd[2]; end
                default: ;
            endcase
        end
        m_stat  = ((m_stat & ~clr) | cond) & IMPL;
        m_sum   = nsum;
        m_alert = nal;
        @(negedge clk);
        check({tag, " R10 rd_data"}, rd_data, m_rd);
        check({tag, " R8 summary"}, {7'b0, summary}, {7'b0, m_sum});
        check({tag, " R9 alert"}, {7'b0, alert}, {7'b0, m_alert});
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check("R7 reset rd", rd_data, 8'h00);
        check("R7 reset summary", {7'b0, summary}, 8'h00);
        check("R7 reset alert", {7'b0, alert}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            cyc(8'h00, 1'b0, 1'b1, a[1:0], 8'h00, "R7 reset regs");
            check("R7 reset reg value", rd_data, 8'h00);
        end

        // R1 sticky capture
        cyc(8'h01, 1'b0, 1'b0, 2'd0, 8'h00, "R1 pulse");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R1 read");
        check("R1 sticky", rd_data, 8'h01);
        check("R8 summary up", {7'b0, summary}, 8'h01);
        check("R9 alert disabled", {7'b0, alert}, 8'h00);

        // R9 enable alert
        cyc(8'h00, 1'b1, 1'b0, 2'd3, 8'h04, "R9 enable");
        cyc(8'h00, 1'b0, 1'b0, 2'd0, 8'h00, "R9 idle");
        check("R9 alert up", {7'b0, alert}, 8'h01);

        // R2 write-one-to-clear
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'h00, "R2 write zero");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R2 read");
        check("R2 zero no effect", rd_data, 8'h01);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'h01, "R2 clear");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R2 read");
        check("R2 cleared", rd_data, 8'h00);

        // R3 clear refused while active
        cyc(8'h02, 1'b0, 1'b0, 2'd0, 8'h00, "R3 set");
        cyc(8'h02, 1'b1, 1'b0, 2'd0, 8'h02, "R3 clear active");
        cyc(8'h02, 1'b0, 1'b1, 2'd0, 8'h00, "R3 read");
        check("R3 set wins", rd_data, 8'h02);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'h02, "R3 clear idle");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R3 read");
        check("R3 cleared after drop", rd_data, 8'h00);

        // R4 static mask
        cyc(8'h00, 1'b1, 1'b0, 2'd1, 8'h02, "R4 mask");
        cyc(8'h02, 1'b0, 1'b0, 2'd0, 8'h00, "R4 masked ev");
        cyc(8'h02, 1'b0, 1'b1, 2'd0, 8'h00, "R4 read");
        check("R4 masked no set", rd_data, 8'h00);
        cyc(8'h02, 1'b1, 1'b0, 2'd1, 8'h00, "R4 unmask");
        cyc(8'h02, 1'b1, 1'b0, 2'd1, 8'h02, "R4 remask");
        cyc(8'h02, 1'b1, 1'b0, 2'd0, 8'h02, "R4 clear masked");
        cyc(8'h02, 1'b0, 1'b1, 2'd0, 8'h00, "R4 read");
        check("R4 masked clear ok", rd_data, 8'h00);
        cyc(8'h00, 1'b1, 1'b0, 2'd1, 8'h00, "R4 unmask");

        // R5 sleep policy
        cyc(8'h00, 1'b1, 1'b0, 2'd3, 8'h05, "R5 S3");
        cyc(8'h3F, 1'b0, 1'b0, 2'd0, 8'h00, "R5 ev");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R5 read");
        check("R5 S3 opt off", rd_data, 8'h33);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R5 clr");
        cyc(8'h00, 1'b1, 1'b0, 2'd2, 8'h01, "R5 opt");
        cyc(8'h3F, 1'b0, 1'b0, 2'd0, 8'h00, "R5 ev");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R5 read");
        check("R5 S3 opt bit0", rd_data, 8'h32);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R5 clr");
        cyc(8'h00, 1'b1, 1'b0, 2'd3, 8'h06, "R5 S45");
        cyc(8'h00, 1'b1, 1'b0, 2'd2, 8'h03, "R5 opt");
        cyc(8'h3F, 1'b0, 1'b0, 2'd0, 8'h00, "R5 ev");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R5 read");
        check("R5 S45 opt all", rd_data, 8'h30);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R5 clr");
        cyc(8'h00, 1'b1, 1'b0, 2'd3, 8'h07, "R5 spare");
        cyc(8'h3F, 1'b0, 1'b0, 2'd0, 8'h00, "R5 ev");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R5 read");
        check("R5 spare no mask", rd_data, 8'h3F);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R5 clr");
        cyc(8'h00, 1'b1, 1'b0, 2'd3, 8'h04, "R5 awake");
        cyc(8'h00, 1'b1, 1'b0, 2'd2, 8'h00, "R5 opt off");

        // R8 excluded bit
        cyc(8'hE0, 1'b0, 1'b0, 2'd0, 8'h00, "R8 ev bit5");
        cyc(8'h00, 1'b0, 1'b0, 2'd0, 8'h00, "R8 idle");
        check("R8 excluded no summary", {7'b0, summary}, 8'h00);
        check("R9 excluded no alert", {7'b0, alert}, 8'h00);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R7 read");
        check("R7 reserved zero", rd_data, 8'h20);

        // R6 read-to-clear
        rc_mode = 1'b1;
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 rc read1");
        check("R6 rc returns old", rd_data, 8'h20);
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 rc read2");
        check("R6 rc cleared", rd_data, 8'h00);
        rc_mode = 1'b0;
        cyc(8'h10, 1'b0, 1'b0, 2'd0, 8'h00, "R6 set");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 read1");
        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 read2");
        check("R6 normal keeps", rd_data, 8'h10);
        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R6 clr");

        // R10 map
        cyc(8'h00, 1'b1, 1'b0, 2'd1, 8'hA5, "R10 mask");
        cyc(8'h00, 1'b0, 1'b1, 2'd1, 8'h00, "R10 read");
        check("R10 mask readback", rd_data, 8'h25);
        cyc(8'h00, 1'b1, 1'b0, 2'd1, 8'h00, "R10 mask0");
        cyc(8'h00, 1'b0, 1'b1, 2'd3, 8'h00, "R10 ctrl");
        check("R10 ctrl readback", rd_data, 8'h04);

        // Sweep: sleep code x opt mask x static mask x clear mode x events
        for (int st = 0; st < 4; st++) begin
            for (int om = 0; om < 2; om++) begin
                for (int sm = 0; sm < 2; sm++) begin
                    rc_mode = sm[0] ^ om[0];
                    cyc(8'h00, 1'b1, 1'b0, 2'd3, {5'b0, 1'b1, st[1:0]}, "R5 sw ctrl");
                    cyc(8'h00, 1'b1, 1'b0, 2'd2, om[0] ? 8'h3F : 8'h00, "R5 sw opt");
                    cyc(8'h00, 1'b1, 1'b0, 2'd1, sm[0] ? 8'h15 : 8'h00, "R4 sw mask");
                    cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R2 sw clr");
                    for (int ev = 0; ev < 64; ev++) begin
                        cyc(ev[7:0], 1'b0, 1'b0, 2'd0, 8'h00, "R1 sw ev");
                        cyc(8'h00, 1'b0, 1'b1, 2'd0, 8'h00, "R6 sw read");
                        cyc(8'h00, 1'b1, 1'b0, 2'd0, 8'hFF, "R2 sw clr");
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule